// File: doc/BRIEF.md
# Codec Serial Port Mode Controller

This block is the converter-side control logic of a full-duplex 16-bit word link to a host processor. In each frame, marked by a one-cycle `frame_sync` pulse, the host's word arrives on `rx_word`. In the same cycle the block registers the word it will return in the next frame on `tx_word`. Five 8-bit control registers hold the configuration. The low nibble of register 0 selects one of five operating modes: program, data, mixed, analog loopback and digital loopback.

Depending on the mode, an incoming word is either a command that writes a control register or a sample for the DAC. The outgoing word is then a sample from the ADC stub, a looped-back value, or an invalid all-zero word. Driving `rst_n` low and then high returns the block to program mode. The converters themselves sit outside the block. The ADC is modelled as the `adc_sample` input, and the DAC as the registered `dac_word` with its strobe.

Top module: `codec_port_ctrl`

## Requirements
- R1: While `rst_n` is low, and after it returns high, all five registers read zero, `mode` is 0 (program), `tx_word` is 0, and `tx_valid` and `dac_strobe` are low.
- R2: In program mode (`mode`=0), every frame's word is a command, whatever its bit 15. It writes bits 7:0 into the register addressed by bits 14:11. Addresses 5 to 15 change nothing. The block returns `tx_word`=0 with `tx_valid` low.
- R3: The value of register 0 bits 3:0 selects the mode, and `mode` reports it: 0001 gives data (1), 0010 gives mixed (2), 0100 gives analog loopback (3), 1000 gives digital loopback (4), and any other value gives program (0). A write to register 0 governs the word of the next frame.
- R4: In data mode, each frame sets `dac_word` to `rx_word` and pulses `dac_strobe` for one cycle. It also sets `tx_word` to `adc_sample` with `tx_valid` high.
- R5: In data mode, no word changes any register, whatever its bit 15. Only a reset leaves data mode.
- R6: In mixed mode, a word with bit 15 = 1 is a command with the R2 layout and gives no DAC strobe. A word with bit 15 = 0 sets `dac_word` to its bits 14:0 followed by a zero LSB, and pulses `dac_strobe`.
- R7: In mixed mode, every frame returns `tx_word` = {0, `adc_sample`[15:1]} with `tx_valid` high.
- R8: In analog loopback, commands and DAC updates follow R6. The returned word is {0, bits 15:1 of `dac_word` as it stood before the frame}, with `tx_valid` high.
- R9: In digital loopback, commands follow R6 and the DAC is left alone (no strobe). The received word is sent back unchanged on the next frame, with `tx_valid` high.
- R10: In a cycle without `frame_sync`, the registers, `tx_word`, `tx_valid` and `dac_word` keep their values, and `dac_strobe` is low on the following cycle.
- R11: A low-then-high pulse on `rst_n` in any mode returns the block to the R1 state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_sync | input | 1 | One-cycle frame boundary strobe |
| rx_word | input | 16 | Word received from the host this frame |
| adc_sample | input | 16 | Stub conversion result to send |
| tx_word | output | 16 | Word to send to the host next frame |
| tx_valid | output | 1 | High when tx_word carries a valid sample |
| dac_word | output | 16 | Last sample handed to the DAC |
| dac_strobe | output | 1 | One-cycle pulse when dac_word is updated |
| mode | output | 3 | Current mode (0 program, 1 data, 2 mixed, 3 analog loop, 4 digital loop) |
| ctrl_regs | output | 40 | Register file, register n in bits 8n+7:8n |

## Verification
The bench writes register 0 and then sends the next word. A design that switched mode a frame early or a frame late would decode that word under the wrong rules and return the wrong kind of output. It sends command-shaped words in data mode, which a design without the lockout would let rewrite the mode. It also sends addresses 5 to 15, which a design without the bound would alias onto a real register. Finally, it checks that analog loopback returns the DAC value from before the current update: a design that forwarded the new value would be a frame early.

// File: rtl/codec_port_ctrl.sv
module codec_port_ctrl #(
  parameter int NREG = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                frame_sync,
  input  logic [15:0]         rx_word,
  input  logic [15:0]         adc_sample,
  output logic [15:0]         tx_word,
  output logic                tx_valid,
  output logic [15:0]         dac_word,
  output logic                dac_strobe,
  output logic [2:0]          mode,
  output logic [8*NREG-1:0]   ctrl_regs
);
  localparam logic [2:0] M_PROG  = 3'd0;
  localparam logic [2:0] M_DATA  = 3'd1;
  localparam logic [2:0] M_MIXED = 3'd2;
  localparam logic [2:0] M_ALOOP = 3'd3;
  localparam logic [2:0] M_DLOOP = 3'd4;

  logic [7:0] regs [NREG];
  logic [3:0] addr;
  logic       is_cmd;
  logic       wr_en;

  always_comb begin
    unique case (regs[0][3:0])
      4'b0001: mode = M_DATA;
      4'b0010: mode = M_MIXED;
      4'b0100: mode = M_ALOOP;
      4'b1000: mode = M_DLOOP;
      default: mode = M_PROG;
    endcase
  end

  assign addr   = rx_word[14:11];
  assign is_cmd = (mode == M_PROG) || ((mode != M_DATA) && rx_word[15]);
  assign wr_en  = frame_sync && is_cmd;

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          regs[i] <= '0;
      else if (wr_en && addr == 4'(i))     regs[i] <= rx_word[7:0];
    end
    assign ctrl_regs[8*i +: 8] = regs[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_word    <= '0;
      tx_valid   <= 1'b0;
      dac_word   <= '0;
      dac_strobe <= 1'b0;
    end else begin
      dac_strobe <= 1'b0;
      if (frame_sync) begin
        case (mode)
          M_DATA: begin
            dac_word   <= rx_word;
            dac_strobe <= 1'b1;
            tx_word    <= adc_sample;
            tx_valid   <= 1'b1;
          end
          M_MIXED, M_ALOOP: begin
            if (!rx_word[15]) begin
              dac_word   <= {rx_word[14:0], 1'b0};
              dac_strobe <= 1'b1;
            end
            tx_word  <= (mode == M_MIXED) ? {1'b0, adc_sample[15:1]}
                                          : {1'b0, dac_word[15:1]};
            tx_valid <= 1'b1;
          end
          M_DLOOP: begin
            tx_word  <= rx_word;
            tx_valid <= 1'b1;
          end
          default: begin
            tx_word  <= '0;
            tx_valid <= 1'b0;
          end
        endcase
      end
    end
  end

  assert_prog_mute_R2: assert property (@(posedge clk) disable iff (!rst_n)
    frame_sync && mode == M_PROG |=> tx_word == 16'd0 && !tx_valid);

  assert_data_path_R4: assert property (@(posedge clk) disable iff (!rst_n)
    frame_sync && mode == M_DATA |=> dac_strobe && dac_word == $past(rx_word)
                                     && tx_word == $past(adc_sample));

  assert_data_lock_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mode == M_DATA |=> $stable(ctrl_regs));

  assert_mixed_cmd_R6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_sync && mode == M_MIXED && rx_word[15] |=> !dac_strobe);

  assert_echo_R9: assert property (@(posedge clk) disable iff (!rst_n)
    frame_sync && mode == M_DLOOP |=> tx_word == $past(rx_word) && !dac_strobe);

  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_sync |=> $stable(ctrl_regs) && $stable(tx_word) && $stable(tx_valid)
                    && $stable(dac_word) && !dac_strobe);
endmodule

// File: tb/codec_port_ctrl_bench.sv
module codec_port_ctrl_bench;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n, frame_sync, tx_valid, dac_strobe;
  logic [15:0] rx_word, adc_sample, tx_word, dac_word;
  logic [2:0]  mode;
  logic [39:0] ctrl_regs;

  codec_port_ctrl u_codec_port_ctrl (
    .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync), .rx_word(rx_word),
    .adc_sample(adc_sample), .tx_word(tx_word), .tx_valid(tx_valid),
    .dac_word(dac_word), .dac_strobe(dac_strobe), .mode(mode), .ctrl_regs(ctrl_regs));

  int n_run = 0, n_fail = 0;
  logic [7:0]  m_r [5];
  logic [15:0] m_tx, m_dac;
  logic        m_val, m_stb;

  function automatic int mode_of(logic [7:0] a);
    case (a[3:0])
      4'b0001: return 1;
      4'b0010: return 2;
      4'b0100: return 3;
      4'b1000: return 4;
      default: return 0;
    endcase
  endfunction

  function automatic logic [15:0] cmd(int a, logic [7:0] v);
    return {1'b1, 4'(a), 3'b000, v};
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic check_all(string tag, string reg_tag);
    chk(tag, 64'(tx_word), 64'(m_tx));
    chk(tag, 64'(tx_valid), 64'(m_val));
    chk(tag, 64'(dac_word), 64'(m_dac));
    chk(tag, 64'(dac_strobe), 64'(m_stb));
    chk(reg_tag, 64'(ctrl_regs), 64'({m_r[4], m_r[3], m_r[2], m_r[1], m_r[0]}));
    chk("R3", 64'(mode), 64'(mode_of(m_r[0])));
  endtask

  task automatic model_reset();
    for (int i = 0; i < 5; i++) m_r[i] = 8'h00;
    m_tx = 0; m_dac = 0; m_val = 0; m_stb = 0;
  endtask

  task automatic do_reset(string tag);
    @(negedge clk); rst_n = 1'b0; frame_sync = 1'b0;
    model_reset();
    @(negedge clk); check_all(tag, tag);
    rst_n = 1'b1;
    @(negedge clk); check_all(tag, tag);
  endtask

  task automatic frame(logic [15:0] w);
    int          md  = mode_of(m_r[0]);
    logic [15:0] adc = 16'($urandom);
    string       tg;
    @(negedge clk);
    rx_word = w; adc_sample = adc; frame_sync = 1'b1;
    m_stb = 1'b0;
    case (md)
      1: begin tg = "R4"; m_dac = w; m_stb = 1; m_tx = adc; m_val = 1; end
      2, 3: begin
        tg = (md == 2) ? (w[15] ? "R6" : "R7") : "R8";
        m_tx  = (md == 2) ? {1'b0, adc[15:1]} : {1'b0, m_dac[15:1]};
        m_val = 1;
        if (w[15]) begin
          if (w[14:11] < 5) m_r[w[14:11]] = w[7:0];
        end else begin
          m_dac = {w[14:0], 1'b0}; m_stb = 1;
        end
      end
      4: begin
        tg = "R9"; m_tx = w; m_val = 1;
        if (w[15] && w[14:11] < 5) m_r[w[14:11]] = w[7:0];
      end
      default: begin
        tg = "R2"; m_tx = 0; m_val = 0;
        if (w[14:11] < 5) m_r[w[14:11]] = w[7:0];
      end
    endcase
    @(negedge clk);
    frame_sync = 1'b0;
    check_all(tg, (md == 1) ? "R5" : tg);
    repeat ($urandom_range(0, 2)) begin
      rx_word = 16'($urandom); adc_sample = 16'($urandom);
      m_stb = 1'b0;
      @(negedge clk);
      check_all("R10", "R10");
    end
  endtask

  task automatic random_run(int n, bit keep_mode);
    for (int k = 0; k < n; k++) begin
      logic [15:0] w = 16'($urandom);
      if (keep_mode && w[15] && w[14:11] == 4'd0) w[14:11] = 4'd1;
      frame(w);
    end
  endtask

  initial begin
    #800000;
    n_run++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] codes [4];
    void'($urandom(32'd7331));
    rst_n = 1'b0; frame_sync = 1'b0; rx_word = 0; adc_sample = 0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1", "R1");

    for (int a = 1; a < 5; a++) frame(cmd(a, 8'($urandom)));
    for (int a = 5; a < 16; a++) frame(cmd(a, 8'($urandom)));
    frame({1'b0, 4'd3, 3'd0, 8'h5A});
    frame(cmd(0, 8'h03));
    frame(16'h1234);
    frame(cmd(0, 8'h02));
    frame(16'h0ABC);
    frame(cmd(0, 8'h00));
    frame(16'h8001);

    codes[0] = 8'h02; codes[1] = 8'h04; codes[2] = 8'h08; codes[3] = 8'h01;
    for (int c = 0; c < 4; c++) begin
      do_reset("R11");
      frame(cmd(0, codes[c]));
      random_run(120, codes[c] != 8'h01);
    end
    frame(cmd(0, 8'h02));
    frame(cmd(0, 8'h08));
    do_reset("R11");
    frame(cmd(0, 8'h04));
    frame(16'h7FFF);
    frame(16'h0000);
    frame(cmd(0, 8'h00));
    frame(16'hFFFF);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule